// File: doc/BRIEF.md
# Display Event Interrupt and Frame-Synchronous Commit Controller

This block gathers the timing events of a display pipeline (vertical sync, the per-field graphics frame event, the frame-done event, and underflow of the video and graphics pixel FIFOs) into one status word. An enable mask qualifies that word, and the block drives a single interrupt line. Status handling follows a two-step protocol. A read can optionally clear the event bits. A write is then required to acknowledge the interrupt and re-arm the line.

The block also holds a bank of display timing registers and a small queue of deferred register updates. Software fills the queue with (target, keep-mask, value) entries and arms a commit. On the next frame-done event that is enabled, the controller replays the queue one entry per clock as read-modify-write operations and clears the frame-done enable bit itself. While a commit is outstanding, the completion pulse that would normally follow vertical sync is held back. Software therefore never sees a frame complete with half of its changes applied.

Top module: `disp_evt_commit`

## Requirements
- R1: After reset, every register reads zero: status, mask, control, queue index and all target registers. `irq_o` and `notify_o` are low.
- R2: Each event input pulse sets a status bit. The bits are: vertical sync at bit 0, graphics frame of field 0 at bit 1, graphics frame of field 1 at bit 2, frame-done at bit 3, video underflow at bit 4 and graphics underflow at bit 5. `field_o` holds the field of the most recent graphics frame. Status is at address 0 and the mask is at address 1.
- R3: `irq_o` is high only while the line is armed and some status bit among bits 0 to 3 is set with its mask bit set. The underflow bits never raise it.
- R4: A write to status clears every status bit whose data bit is 0 and re-arms the line. Any status read disarms the line, so no further interrupt occurs until the next status write.
- R5: When control bit 0 (address 2) is 1, a status read clears the event bits 0 to 3 that it returned. When control bit 0 is 0, a read clears nothing.
- R6: A mask write that turns a bit from 0 to 1 clears that status bit if it was already set.
- R7: Queue entries are written at the queue index (address 3). Address 4 takes the target number in bits [2:0] and an end marker in bit 31. Address 5 takes the keep-mask. Address 6 takes the value and advances the index, wrapping after the last slot. Writing 1 to control bit 1 arms a commit, and control bit 1 reads back as commit-pending.
- R8: A frame-done event with mask bit 3 set and a commit pending replays the queue from entry 0 in order. For each entry, the new target value is (old AND keep) OR value, with no old bits kept when keep is 0. The replay stops at an end marker or after the last slot, and then pending clears.
- R9: A frame-done event with mask bit 3 set clears mask bit 3 one cycle later. When mask bit 3 is clear, frame-done applies no queued entry and pending stays set.
- R10: `notify_o` pulses one cycle after a vertical sync pulse only if no commit is pending.
- R11: Underflow status bits stay set until a status write clears them. Clean-on-read leaves them set, and they never start a commit.
- R12: The target registers at addresses 8 to 15 can be read and written directly, and their values appear on `tgt_regs_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync event pulse |
| gfx_frame_i | input | 1 | Graphics frame event pulse |
| gfx_field_i | input | 1 | Field of the graphics frame event |
| frame_done_i | input | 1 | Frame-done event pulse |
| vid_underflow_i | input | 1 | Video FIFO underflow pulse |
| gfx_underflow_i | input | 1 | Graphics FIFO underflow pulse |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |
| notify_o | output | 1 | Frame completion pulse |
| field_o | output | 1 | Field of the last graphics frame |
| tgt_regs_o | output | 32*2^(ADDR_W-1) | Target register bank, flattened |

## Verification
The bench uses the default parameters: a 16-slot queue and a 4-bit address that maps eight target registers. With these values, a queue filled to the last slot with no end marker is reachable, so the walker's stop after the final slot and the wrap of the write index are both exercised. Eight targets allow a replay to mix two read-modify-write entries on the same register with entries on separate registers. The order of those entries on the shared register gives different results, so the order of replay is visible.

// File: rtl/disp_evt_pkg.sv
`timescale 1ns/1ps
package disp_evt_pkg;
  localparam int DW    = 32;
  localparam int EVT_N = 6;

  localparam int EV_VSYNC = 0;
  localparam int EV_GFX0  = 1;
  localparam int EV_GFX1  = 2;
  localparam int EV_FDONE = 3;
  localparam int EV_VUF   = 4;
  localparam int EV_GUF   = 5;

  // sources that raise the line and that clean-on-read may clear
  localparam logic [EVT_N-1:0] HANDLED_M = 6'b00_1111;

  typedef enum logic [2:0] {
    RS_STAT  = 3'd0,
    RS_MASK  = 3'd1,
    RS_CTRL  = 3'd2,
    RS_QIDX  = 3'd3,
    RS_QTGT  = 3'd4,
    RS_QKEEP = 3'd5,
    RS_QVAL  = 3'd6,
    RS_RSVD  = 3'd7
  } regsel_e;
endpackage

// File: rtl/disp_evt_status.sv
`timescale 1ns/1ps
module disp_evt_status
  import disp_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_set_i,
  input  logic             stat_rd_i,
  input  logic             clean_rd_i,
  input  logic             stat_wr_i,
  input  logic             mask_wr_i,
  input  logic [EVT_N-1:0] wdata_i,
  input  logic             fd_served_i,
  output logic [EVT_N-1:0] status_o,
  output logic [EVT_N-1:0] mask_o,
  output logic             armed_o,
  output logic             irq_o
);
  logic [EVT_N-1:0] status_q, status_d, mask_q, mask_d, clr;
  logic             armed_q, armed_d;

  always_comb begin
    clr = '0;
    if (stat_rd_i && clean_rd_i) clr = clr | (status_q & HANDLED_M);
    if (stat_wr_i)               clr = clr | ~wdata_i;
    if (mask_wr_i)               clr = clr | (wdata_i & ~mask_q & status_q); // stale on enable
    status_d = (status_q & ~clr) | evt_set_i;

    mask_d = mask_wr_i ? wdata_i : mask_q;
    if (fd_served_i) mask_d[EV_FDONE] = 1'b0;

    armed_d = armed_q;
    if (stat_wr_i)      armed_d = 1'b1;
    else if (stat_rd_i) armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
      armed_q  <= 1'b1;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      armed_q  <= armed_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign armed_o  = armed_q;
  assign irq_o    = armed_q & |(status_q & mask_q & HANDLED_M);
endmodule

// File: rtl/disp_evt_cqueue.sv
`timescale 1ns/1ps
module disp_evt_cqueue
  import disp_evt_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TGT_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     wdata_i,
  input  logic              idx_wr_i,
  input  logic              tgt_wr_i,
  input  logic              keep_wr_i,
  input  logic              val_wr_i,
  input  logic              arm_i,
  input  logic              start_i,
  output logic [DW-1:0]     idx_o,
  output logic              pending_o,
  output logic              busy_o,
  output logic              app_vld_o,
  output logic [TGT_AW-1:0] app_tgt_o,
  output logic [DW-1:0]     app_keep_o,
  output logic [DW-1:0]     app_val_o
);
  localparam int QAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [QAW-1:0] LAST = QAW'(DEPTH - 1);

  logic              q_end  [DEPTH];
  logic [TGT_AW-1:0] q_tgt  [DEPTH];
  logic [DW-1:0]     q_keep [DEPTH];
  logic [DW-1:0]     q_val  [DEPTH];

  logic [QAW-1:0] idx_q, ptr_q;
  logic           busy_q, pending_q, stop;

  assign stop = q_end[ptr_q] || (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        q_end[i]  <= 1'b1;
        q_tgt[i]  <= '0;
        q_keep[i] <= '0;
        q_val[i]  <= '0;
      end
      idx_q <= '0;
    end else begin
      if (idx_wr_i) idx_q <= wdata_i[QAW-1:0];
      if (tgt_wr_i) begin
        q_end[idx_q] <= wdata_i[DW-1];
        q_tgt[idx_q] <= wdata_i[TGT_AW-1:0];
      end
      if (keep_wr_i) q_keep[idx_q] <= wdata_i;
      if (val_wr_i) begin
        q_val[idx_q] <= wdata_i;
        idx_q        <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      ptr_q     <= '0;
      pending_q <= 1'b0;
    end else begin
      if (busy_q) begin
        if (stop) begin
          busy_q    <= 1'b0;
          pending_q <= 1'b0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else begin
        if (arm_i) pending_q <= 1'b1;
        if (start_i && pending_q) begin
          busy_q <= 1'b1;
          ptr_q  <= '0;
        end
      end
    end
  end

  assign idx_o      = DW'(idx_q);
  assign pending_o  = pending_q;
  assign busy_o     = busy_q;
  assign app_vld_o  = busy_q & ~q_end[ptr_q];
  assign app_tgt_o  = q_tgt[ptr_q];
  assign app_keep_o = q_keep[ptr_q];
  assign app_val_o  = q_val[ptr_q];
endmodule

// File: rtl/disp_evt_tgtbank.sv
`timescale 1ns/1ps
module disp_evt_tgtbank
  import disp_evt_pkg::*;
#(
  parameter int TGT_AW = 3,
  parameter int TGT_N  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [TGT_AW-1:0] bus_idx_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              app_vld_i,
  input  logic [TGT_AW-1:0] app_tgt_i,
  input  logic [DW-1:0]     app_keep_i,
  input  logic [DW-1:0]     app_val_i,
  output logic [TGT_N*DW-1:0] regs_o
);
  for (genvar g = 0; g < TGT_N; g++) begin : g_reg
    localparam logic [TGT_AW-1:0] SEL = TGT_AW'(g);
    logic [DW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
      end else if (app_vld_i && app_tgt_i == SEL) begin
        // keep-mask of zero keeps nothing
        r_q <= ((app_keep_i != '0) ? (r_q & app_keep_i) : '0) | app_val_i;
      end else if (bus_wr_i && bus_idx_i == SEL) begin
        r_q <= wdata_i;
      end
    end
    assign regs_o[g*DW +: DW] = r_q;
  end
endmodule

// File: rtl/disp_evt_commit.sv
`timescale 1ns/1ps
module disp_evt_commit
  import disp_evt_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int ADDR_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           vsync_i,
  input  logic                           gfx_frame_i,
  input  logic                           gfx_field_i,
  input  logic                           frame_done_i,
  input  logic                           vid_underflow_i,
  input  logic                           gfx_underflow_i,
  input  logic                           bus_we_i,
  input  logic                           bus_re_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [31:0]                    bus_wdata_i,
  output logic [31:0]                    bus_rdata_o,
  output logic                           irq_o,
  output logic                           notify_o,
  output logic                           field_o,
  output logic [(1<<(ADDR_W-1))*32-1:0]  tgt_regs_o
);
  localparam int TGT_AW = ADDR_W - 1;
  localparam int TGT_N  = 1 << TGT_AW;

  logic              is_tgt;
  regsel_e           sel;
  logic [TGT_AW-1:0] tgt_idx;
  logic              stat_wr, stat_rd, mask_wr, ctrl_wr, tgt_wr;
  logic              qidx_wr, qtgt_wr, qkeep_wr, qval_wr;
  logic [EVT_N-1:0]  evt_set, evt_status, evt_mask;
  logic              armed, fd_served;
  logic              clean_rd_q, notify_q, field_q;
  logic              cmt_pending, cmt_busy, app_vld;
  logic [TGT_AW-1:0] app_tgt;
  logic [DW-1:0]     app_keep, app_val, qidx;

  assign is_tgt  = bus_addr_i[ADDR_W-1];
  assign sel     = regsel_e'(bus_addr_i[2:0]);
  assign tgt_idx = bus_addr_i[TGT_AW-1:0];

  assign stat_wr  = bus_we_i & ~is_tgt & (sel == RS_STAT);
  assign stat_rd  = bus_re_i & ~is_tgt & (sel == RS_STAT);
  assign mask_wr  = bus_we_i & ~is_tgt & (sel == RS_MASK);
  assign ctrl_wr  = bus_we_i & ~is_tgt & (sel == RS_CTRL);
  assign qidx_wr  = bus_we_i & ~is_tgt & (sel == RS_QIDX);
  assign qtgt_wr  = bus_we_i & ~is_tgt & (sel == RS_QTGT);
  assign qkeep_wr = bus_we_i & ~is_tgt & (sel == RS_QKEEP);
  assign qval_wr  = bus_we_i & ~is_tgt & (sel == RS_QVAL);
  assign tgt_wr   = bus_we_i & is_tgt;

  always_comb begin
    evt_set           = '0;
    evt_set[EV_VSYNC] = vsync_i;
    evt_set[EV_GFX0]  = gfx_frame_i & ~gfx_field_i;
    evt_set[EV_GFX1]  = gfx_frame_i & gfx_field_i;
    evt_set[EV_FDONE] = frame_done_i;
    evt_set[EV_VUF]   = vid_underflow_i;
    evt_set[EV_GUF]   = gfx_underflow_i;
  end

  assign fd_served = frame_done_i & evt_mask[EV_FDONE];

  disp_evt_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_set_i   (evt_set),
    .stat_rd_i   (stat_rd),
    .clean_rd_i  (clean_rd_q),
    .stat_wr_i   (stat_wr),
    .mask_wr_i   (mask_wr),
    .wdata_i     (bus_wdata_i[EVT_N-1:0]),
    .fd_served_i (fd_served),
    .status_o    (evt_status),
    .mask_o      (evt_mask),
    .armed_o     (armed),
    .irq_o       (irq_o)
  );

  disp_evt_cqueue #(.DEPTH(QDEPTH), .TGT_AW(TGT_AW)) u_cqueue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdata_i    (bus_wdata_i),
    .idx_wr_i   (qidx_wr),
    .tgt_wr_i   (qtgt_wr),
    .keep_wr_i  (qkeep_wr),
    .val_wr_i   (qval_wr),
    .arm_i      (ctrl_wr & bus_wdata_i[1]),
    .start_i    (fd_served),
    .idx_o      (qidx),
    .pending_o  (cmt_pending),
    .busy_o     (cmt_busy),
    .app_vld_o  (app_vld),
    .app_tgt_o  (app_tgt),
    .app_keep_o (app_keep),
    .app_val_o  (app_val)
  );

  disp_evt_tgtbank #(.TGT_AW(TGT_AW), .TGT_N(TGT_N)) u_tgtbank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_wr_i   (tgt_wr),
    .bus_idx_i  (tgt_idx),
    .wdata_i    (bus_wdata_i),
    .app_vld_i  (app_vld),
    .app_tgt_i  (app_tgt),
    .app_keep_i (app_keep),
    .app_val_i  (app_val),
    .regs_o     (tgt_regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clean_rd_q <= 1'b0;
      notify_q   <= 1'b0;
      field_q    <= 1'b0;
    end else begin
      if (ctrl_wr)     clean_rd_q <= bus_wdata_i[0];
      if (gfx_frame_i) field_q    <= gfx_field_i;
      notify_q <= vsync_i & ~cmt_pending;
    end
  end

  assign notify_o = notify_q;
  assign field_o  = field_q;

  always_comb begin
    bus_rdata_o = '0;
    if (is_tgt) begin
      bus_rdata_o = tgt_regs_o[tgt_idx*DW +: DW];
    end else begin
      case (sel)
        RS_STAT: bus_rdata_o = DW'(evt_status);
        RS_MASK: bus_rdata_o = DW'(evt_mask);
        RS_CTRL: bus_rdata_o = {30'b0, cmt_pending, clean_rd_q};
        RS_QIDX: bus_rdata_o = qidx;
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

module disp_evt_commit_chk
  import disp_evt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_done_i,
  input logic             irq_o,
  input logic             notify_o,
  input logic [EVT_N-1:0] status_i,
  input logic [EVT_N-1:0] mask_i,
  input logic             armed_i,
  input logic             stat_wr_i,
  input logic             mask_wr_i,
  input logic             busy_i,
  input logic             pending_i
);
  assert_irq_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(status_i & mask_i & HANDLED_M));

  assert_single_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !stat_wr_i) |=> !irq_o);

  assert_busy_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> pending_i);

  assert_fd_selfclear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && mask_i[EV_FDONE]) |=> !mask_i[EV_FDONE]);

  assert_notify_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> !$past(pending_i));

  assert_underflow_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[EV_VUF] && !stat_wr_i && !mask_wr_i) |=> status_i[EV_VUF]);
endmodule

bind disp_evt_commit disp_evt_commit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_done_i (frame_done_i),
  .irq_o        (irq_o),
  .notify_o     (notify_o),
  .status_i     (evt_status),
  .mask_i       (evt_mask),
  .armed_i      (armed),
  .stat_wr_i    (stat_wr),
  .mask_wr_i    (mask_wr),
  .busy_i       (cmt_busy),
  .pending_i    (cmt_pending)
);

// File: tb/disp_evt_commit_bench.sv
`timescale 1ns/1ps
module disp_evt_commit_bench;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_STAT = 4'd0, A_MASK = 4'd1, A_CTRL = 4'd2, A_QIDX = 4'd3,
                            A_QTGT = 4'd4, A_QKEEP = 4'd5, A_QVAL = 4'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vsync = 0, gfx = 0, field = 0, fdone = 0, vuf = 0, guf = 0;
  logic we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, notify, field_out;
  logic [8*32-1:0] tregs;

  int n_chk = 0, n_fail = 0;
  logic notify_s;
  logic [31:0] d;

  always #5 clk = ~clk;

  disp_evt_commit u_disp_evt_commit (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .gfx_frame_i(gfx), .gfx_field_i(field),
    .frame_done_i(fdone), .vid_underflow_i(vuf), .gfx_underflow_i(guf),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .notify_o(notify), .field_o(field_out),
    .tgt_regs_o(tregs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
    @(negedge clk); we = 1; addr = a; wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); re = 1; addr = a;
    #1 v = rdata;
    @(negedge clk); re = 0;
  endtask

  // bits: 0 vsync, 1 gfx, 2 frame-done, 3 vuf, 4 guf
  task automatic pulse(input logic [4:0] ev, input logic f);
    @(negedge clk);
    vsync = ev[0]; gfx = ev[1]; field = f; fdone = ev[2]; vuf = ev[3]; guf = ev[4];
    @(negedge clk);
    notify_s = notify;
    vsync = 0; gfx = 0; field = 0; fdone = 0; vuf = 0; guf = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qent(input logic [31:0] t, input logic [31:0] k, input logic [31:0] v);
    wr(A_QTGT, t); wr(A_QKEEP, k); wr(A_QVAL, v);
  endtask

  task automatic t_reset;
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_QIDX, d); chk("R1 qidx", d, 0);
    rd(4'd8, d);   chk("R1 tgt0", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 notify", {31'b0, notify}, 0);
    wr(4'd8, 32'h1234_5678); rd(4'd8, d); chk("R12 tgt0 rw", d, 32'h1234_5678);
    wr(4'd9, 32'hCAFE_0001); chk("R12 tgt1 port", tregs[1*32 +: 32], 32'hCAFE_0001);
  endtask

  task automatic t_events;
    pulse(5'b00001, 0); chk("R3 masked vsync no irq", {31'b0, irq}, 0);
    rd(A_STAT, d); chk("R2 vsync bit0", d, 32'h1);
    pulse(5'b00010, 1); chk("R2 field1", {31'b0, field_out}, 1);
    rd(A_STAT, d); chk("R2 gfx field1 bit2", d, 32'h5);
    pulse(5'b00010, 0); chk("R2 field0", {31'b0, field_out}, 0);
    pulse(5'b00100, 0);
    rd(A_STAT, d); chk("R2 gfx0 and fdone bits", d, 32'hF);
    wr(A_STAT, 0); wr(A_MASK, 32'h30); wr(A_STAT, 0);
    pulse(5'b11000, 0); chk("R3 underflow no irq", {31'b0, irq}, 0);
    rd(A_STAT, d); chk("R2 underflow bits", d, 32'h30);
  endtask

  task automatic t_clean;
    wr(A_CTRL, 1);
    pulse(5'b00001, 0);
    rd(A_STAT, d); chk("R5 clean read value", d, 32'h31);
    rd(A_STAT, d); chk("R11 underflow survives clean read", d, 32'h30);
    wr(A_CTRL, 0);
    pulse(5'b00001, 0);
    rd(A_STAT, d); rd(A_STAT, d); chk("R5 no clear when off", d, 32'h31);
    wr(A_STAT, 32'h20);
    rd(A_STAT, d); chk("R4 write clears zero bits", d, 32'h20);
    wr(A_STAT, 0); wr(A_MASK, 0);
  endtask

  task automatic t_irq;
    wr(A_STAT, 0); wr(A_MASK, 1);
    pulse(5'b00001, 0); chk("R3 enabled vsync irq", {31'b0, irq}, 1);
    rd(A_STAT, d); chk("R4 irq drops on read", {31'b0, irq}, 0);
    pulse(5'b00001, 0); chk("R4 no second irq", {31'b0, irq}, 0);
    wr(A_STAT, 0);
    pulse(5'b00001, 0); chk("R4 rearmed irq", {31'b0, irq}, 1);
    wr(A_MASK, 0); wr(A_STAT, 0);
  endtask

  task automatic t_stale;
    pulse(5'b00010, 0);
    wr(A_MASK, 32'h2);
    rd(A_STAT, d); chk("R6 stale cleared", d, 0);
    pulse(5'b00010, 0);
    rd(A_STAT, d); chk("R6 new event sets", d, 32'h2);
    wr(A_MASK, 0); wr(A_STAT, 0);
  endtask

  task automatic t_commit;
    wr(4'd10, 32'hAAAA_5555);
    wr(A_QIDX, 0);
    qent(2, 32'hFFFF_0000, 32'h0000_1234);
    qent(2, 32'h0000_00FF, 32'h0000_0100);
    qent(5, 0, 32'hDEAD_BEEF);
    wr(A_QTGT, 32'h8000_0000);
    wr(A_QIDX, 4);
    qent(6, 0, 32'h1);
    rd(A_QIDX, d); chk("R7 index advance", d, 5);
    pulse(5'b00001, 0); chk("R10 notify when idle", {31'b0, notify_s}, 1);
    wr(A_CTRL, 2);
    rd(A_CTRL, d); chk("R7 pending readback", d, 2);
    wr(A_MASK, 32'h8);
    pulse(5'b00001, 0); chk("R10 notify withheld", {31'b0, notify_s}, 0);
    rd(4'd10, d); chk("R8 no early apply", d, 32'hAAAA_5555);
    pulse(5'b00100, 0);
    idle(25);
    rd(4'd10, d); chk("R8 ordered rmw", d, 32'h0000_0134);
    rd(4'd13, d); chk("R8 keep zero", d, 32'hDEAD_BEEF);
    rd(4'd14, d); chk("R8 end marker stops", d, 0);
    rd(A_MASK, d); chk("R9 fd enable selfclear", d, 0);
    rd(A_CTRL, d); chk("R8 pending cleared", d, 0);
    pulse(5'b00001, 0); chk("R10 notify after commit", {31'b0, notify_s}, 1);
    wr(A_STAT, 0);
  endtask

  task automatic t_noen;
    wr(A_QIDX, 0);
    qent(3, 0, 32'h5);
    wr(A_QTGT, 32'h8000_0000);
    wr(A_CTRL, 2);
    pulse(5'b00100, 0); idle(5);
    rd(4'd11, d); chk("R9 disabled fd no apply", d, 0);
    rd(A_CTRL, d); chk("R9 pending held", d, 2);
    pulse(5'b11000, 0); idle(5);
    rd(4'd11, d); chk("R11 underflow no commit", d, 0);
    wr(A_MASK, 32'h8);
    pulse(5'b00100, 0); idle(5);
    rd(4'd11, d); chk("R8 apply once enabled", d, 5);
    wr(A_STAT, 0);
  endtask

  task automatic t_full;
    wr(A_QIDX, 0);
    for (int i = 0; i < 16; i++) qent(7, 32'hFFFF_FFFF, 32'h1 << i);
    rd(A_QIDX, d); chk("R7 index wraps", d, 0);
    wr(A_CTRL, 2); wr(A_MASK, 32'h8);
    pulse(5'b00100, 0); idle(30);
    rd(4'd15, d); chk("R8 full depth applied", d, 32'h0000_FFFF);
    rd(A_CTRL, d); chk("R8 full depth done", d, 0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_events;
    t_clean;
    t_irq;
    t_stale;
    t_commit;
    t_noen;
    t_full;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule